// File: doc/BRIEF.md
# Dual-Issue Hardware Breakpoint Controller

This block watches the instruction addresses a two-wide core issues and decides when the core must stop for a hardware breakpoint. The core issues either one instruction (the older lane, A) or an adjacent pair (A older, B younger) in one cycle. Each breakpoint slot holds a halfword address, an enable and a mode that asks for a stop either before the instruction runs or after it completes.

A paired issue cannot be split, so a hit on either member is moved to the pair's edges. A before-stop always lands ahead of A and an after-stop always lands after B. Several hits of the same kind collapse into one stop. A pair that carries both kinds stops first before A and keeps an after-stop pending. That pending stop is raised on the first issue after the debugger resumes the core, which is the re-issue of the same pair.

The resume input clears the halted state. After a resume from a before-stop, before-mode hits at the resume address are ignored for exactly one issue, so the core can step past the instruction it stopped on. Breakpoints on consecutive unpaired instructions therefore each stop in turn.

Top module: `bp_pair_ctrl`

## Requirements
- R1: After reset `halt_req` is 0, `halt_why` is 0 and `halted` is 0. All slots are disabled, so an issue at any address, including 0, causes no halt.
- R2: A cycle with `cfg_we`=1 writes the slot selected by `cfg_idx` (4 slots): address `cfg_addr`, enable `cfg_en`, and mode `cfg_after` (0 = stop before, 1 = stop after). Address bit 0 is ignored in every compare. A disabled slot never hits.
- R3: With only lane A valid, a before-mode hit halts with `halt_why`=2'b01 and an after-mode hit halts with `halt_why`=2'b10. An issue with no hit gives no halt.
- R4: For a pair whose hits are all before-mode (on A, on B, or on both), exactly one halt is raised, with `halt_why`=2'b01.
- R5: For a pair whose hits are all after-mode (on A, on B, or on both), exactly one halt is raised, with `halt_why`=2'b10.
- R6: For a pair with both a before-mode and an after-mode hit, the first halt has `halt_why`=2'b01. The first issue after the following resume halts with `halt_why`=2'b11, whatever that issue matches.
- R7: `halt_req` is a one-cycle pulse in the cycle after the issue. `halted` rises with it and stays 1 until a `resume`. Issues while halted cause no halt. A `resume` while not halted has no effect.
- R8: After resuming from a before-halt, before-mode hits whose address equals `resume_addr` are suppressed for the first issue only. A second issue at that address halts again.
- R9: After resuming from an after-halt there is no suppression, so a before-mode breakpoint at `resume_addr` halts on the next issue.
- R10: `iss_b_vld` without `iss_a_vld` is not an issue and causes no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Breakpoint slot write strobe |
| cfg_idx | input | 2 | Slot being written |
| cfg_addr | input | 32 | Breakpoint address (bit 0 ignored) |
| cfg_en | input | 1 | Slot enable |
| cfg_after | input | 1 | Mode: 0 before, 1 after |
| iss_a_vld | input | 1 | Older lane issues this cycle |
| iss_a_addr | input | 32 | Older lane instruction address |
| iss_b_vld | input | 1 | Younger lane issues with A |
| iss_b_addr | input | 32 | Younger lane instruction address |
| resume | input | 1 | Core resumes from halt |
| resume_addr | input | 32 | Address execution resumes at |
| halt_req | output | 1 | One-cycle halt request |
| halt_why | output | 2 | Reason: 01 before, 10 after, 11 pending-after |
| halted | output | 1 | Core held in halt |

## Verification
A lost pending flag appears as a missing 2'b11 stop on the first issue after a mixed pair is resumed. A pending flag that is wrongly set appears as a spurious stop at that same point. A suppression flag stuck high or armed after an after-stop hides the next breakpoint at the resume address. One that never arms makes the core stop again on the instruction it just left. Both show within two issues of the resume. A wrong halted state shows at once: either a second `halt_req` pulse on an issue the core should not be making, or a stop the debugger never sees.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    WHY_NONE   = 2'b00,
    WHY_BEFORE = 2'b01,
    WHY_AFTER  = 2'b10,
    WHY_PEND   = 2'b11
  } halt_why_e;

  typedef struct packed {
    logic en;
    logic after;
  } bp_mode_t;
endpackage

// File: rtl/bpc_regs.sv
module bpc_regs #(
  parameter int NBP    = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NBP)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic                           cfg_en,
  input  logic                           cfg_after,
  output logic [NBP-1:0][ADDR_W-1:0]     bp_addr,
  output bpc_pkg::bp_mode_t [NBP-1:0]    bp_mode
);
  for (genvar i = 0; i < NBP; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        bp_addr[i] <= '0;
        bp_mode[i] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
        bp_addr[i]       <= cfg_addr;
        bp_mode[i].en    <= cfg_en;
        bp_mode[i].after <= cfg_after;
      end
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_idx == IDX_W'(i)) |=>
        (bp_addr[i] == $past(cfg_addr) && bp_mode[i].en == $past(cfg_en))); // R2
  end
endmodule

// File: rtl/bpc_match.sv
module bpc_match #(
  parameter int NBP    = 4,
  parameter int ADDR_W = 32
) (
  input  logic                        vld,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        sup_bef,
  input  logic [NBP-1:0][ADDR_W-1:0]  bp_addr,
  input  bpc_pkg::bp_mode_t [NBP-1:0] bp_mode,
  output logic                        hit_bef,
  output logic                        hit_aft
);
  localparam logic [ADDR_W-1:0] HW_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

  logic raw_bef;

  always_comb begin
    raw_bef = 1'b0;
    hit_aft = 1'b0;
    for (int i = 0; i < NBP; i++) begin
      if (vld && bp_mode[i].en && (((bp_addr[i] ^ addr) & HW_MASK) == '0)) begin
        if (bp_mode[i].after) hit_aft = 1'b1;
        else                  raw_bef = 1'b1;
      end
    end
    hit_bef = raw_bef & ~sup_bef;
  end
endmodule

// File: rtl/bpc_seq.sv
module bpc_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              bef_any,
  input  logic              aft_any,
  input  logic              resume,
  input  logic [ADDR_W-1:0] resume_addr,
  output logic              halt_req,
  output logic [1:0]        halt_why,
  output logic              halted,
  output logic              sup_arm,
  output logic [ADDR_W-1:0] sup_addr
);
  import bpc_pkg::*;

  logic pending;
  logic last_bef;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req <= 1'b0;
      halt_why <= WHY_NONE;
      halted   <= 1'b0;
      pending  <= 1'b0;
      last_bef <= 1'b0;
      sup_arm  <= 1'b0;
      sup_addr <= '0;
    end else begin
      halt_req <= 1'b0;
      halt_why <= WHY_NONE;
      if (halted) begin
        if (resume) begin
          halted   <= 1'b0;
          sup_arm  <= last_bef;
          sup_addr <= resume_addr;
        end
      end else if (issue) begin
        sup_arm <= 1'b0;
        if (pending) begin
          halt_req <= 1'b1;
          halt_why <= WHY_PEND;
          halted   <= 1'b1;
          pending  <= 1'b0;
          last_bef <= 1'b0;
        end else if (bef_any) begin
          halt_req <= 1'b1;
          halt_why <= WHY_BEFORE;
          halted   <= 1'b1;
          pending  <= aft_any;
          last_bef <= 1'b1;
        end else if (aft_any) begin
          halt_req <= 1'b1;
          halt_why <= WHY_AFTER;
          halted   <= 1'b1;
          last_bef <= 1'b0;
        end
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req); // R7
  AST_HALT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> halted); // R7
  AST_QUIET_HALTED: assert property (@(posedge clk) disable iff (rst)
    halted |=> !halt_req); // R7
  AST_PEND_FROM_MIX: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> (halt_why == WHY_BEFORE)); // R6
  AST_PEND_FIRES: assert property (@(posedge clk) disable iff (rst)
    (pending && !halted && issue) |=> (halt_req && halt_why == WHY_PEND)); // R6
  AST_SUP_ONCE: assert property (@(posedge clk) disable iff (rst)
    (sup_arm && issue && !halted) |=> !sup_arm); // R8
endmodule

// File: rtl/bp_pair_ctrl.sv
module bp_pair_ctrl #(
  parameter int NBP    = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NBP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic              cfg_after,
  input  logic              iss_a_vld,
  input  logic [ADDR_W-1:0] iss_a_addr,
  input  logic              iss_b_vld,
  input  logic [ADDR_W-1:0] iss_b_addr,
  input  logic              resume,
  input  logic [ADDR_W-1:0] resume_addr,
  output logic              halt_req,
  output logic [1:0]        halt_why,
  output logic              halted
);
  import bpc_pkg::*;

  localparam int NLANE = 2;
  localparam logic [ADDR_W-1:0] HW_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

  logic [NBP-1:0][ADDR_W-1:0] bp_addr;
  bp_mode_t [NBP-1:0]         bp_mode;
  logic                       sup_arm;
  logic [ADDR_W-1:0]          sup_addr;
  logic [NLANE-1:0]           lane_vld;
  logic [NLANE-1:0][ADDR_W-1:0] lane_addr;
  logic [NLANE-1:0]           lane_bef;
  logic [NLANE-1:0]           lane_aft;

  assign lane_vld[0]  = iss_a_vld;
  assign lane_vld[1]  = iss_a_vld & iss_b_vld;
  assign lane_addr[0] = iss_a_addr;
  assign lane_addr[1] = iss_b_addr;

  bpc_regs #(.NBP(NBP), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_en(cfg_en), .cfg_after(cfg_after),
    .bp_addr(bp_addr), .bp_mode(bp_mode)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic sup_here;
    assign sup_here = sup_arm && (((lane_addr[l] ^ sup_addr) & HW_MASK) == '0);

    bpc_match #(.NBP(NBP), .ADDR_W(ADDR_W)) u_match (
      .vld(lane_vld[l]), .addr(lane_addr[l]), .sup_bef(sup_here),
      .bp_addr(bp_addr), .bp_mode(bp_mode),
      .hit_bef(lane_bef[l]), .hit_aft(lane_aft[l])
    );
  end

  bpc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .issue(iss_a_vld),
    .bef_any(|lane_bef), .aft_any(|lane_aft),
    .resume(resume), .resume_addr(resume_addr),
    .halt_req(halt_req), .halt_why(halt_why), .halted(halted),
    .sup_arm(sup_arm), .sup_addr(sup_addr)
  );

  AST_WHY_VALID: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> (halt_why != WHY_NONE)); // R3
  AST_NO_B_ALONE: assert property (@(posedge clk) disable iff (rst)
    (!iss_a_vld && !halted) |=> !halt_req); // R10
endmodule

// File: tb/bp_pair_ctrl_tb.sv
module bp_pair_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_addr = '0;
  logic        cfg_en = 1'b0;
  logic        cfg_after = 1'b0;
  logic        iss_a_vld = 1'b0;
  logic [31:0] iss_a_addr = '0;
  logic        iss_b_vld = 1'b0;
  logic [31:0] iss_b_addr = '0;
  logic        resume = 1'b0;
  logic [31:0] resume_addr = '0;
  logic        halt_req;
  logic [1:0]  halt_why;
  logic        halted;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bp_pair_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_en(cfg_en), .cfg_after(cfg_after),
    .iss_a_vld(iss_a_vld), .iss_a_addr(iss_a_addr),
    .iss_b_vld(iss_b_vld), .iss_b_addr(iss_b_addr),
    .resume(resume), .resume_addr(resume_addr),
    .halt_req(halt_req), .halt_why(halt_why), .halted(halted)
  );

  typedef struct packed {
    logic        av;
    logic [31:0] aa;
    logic        bv;
    logic [31:0] ba;
    logic        req;
    logic [1:0]  why;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 32'h1000, 1'b0, 32'h0,    1'b1, 2'b01},  // R3 before, A alone
    '{1'b1, 32'h2000, 1'b0, 32'h0,    1'b1, 2'b10},  // R3 after, A alone
    '{1'b1, 32'h3000, 1'b0, 32'h0,    1'b0, 2'b00},  // R3 no hit
    '{1'b1, 32'h0FFE, 1'b1, 32'h1000, 1'b1, 2'b01},  // R4 before on B
    '{1'b1, 32'h1004, 1'b1, 32'h1006, 1'b1, 2'b01},  // R4 before on A
    '{1'b1, 32'h1000, 1'b1, 32'h1004, 1'b1, 2'b01},  // R4 before on both
    '{1'b1, 32'h2000, 1'b1, 32'h2002, 1'b1, 2'b10},  // R5 after on both
    '{1'b1, 32'h1FFE, 1'b1, 32'h2000, 1'b1, 2'b10},  // R5 after on B
    '{1'b1, 32'h3000, 1'b1, 32'h3002, 1'b0, 2'b00},  // R4 pair, no hit
    '{1'b1, 32'h1001, 1'b0, 32'h0,    1'b1, 2'b01},  // R2 bit 0 ignored
    '{1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'b00}   // R10 B alone
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] idx, input logic [31:0] a, input logic en, input logic aft);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_addr = a; cfg_en = en; cfg_after = aft;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic av, input logic [31:0] aa, input logic bv, input logic [31:0] ba,
                       output logic req, output logic [1:0] why);
    @(negedge clk);
    iss_a_vld = av; iss_a_addr = aa; iss_b_vld = bv; iss_b_addr = ba;
    @(negedge clk);
    req = halt_req; why = halt_why;
    iss_a_vld = 1'b0; iss_b_vld = 1'b0;
  endtask

  task automatic do_resume(input logic [31:0] a);
    @(negedge clk);
    resume = 1'b1; resume_addr = a;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic settle();
    logic r;
    logic [1:0] w;
    if (halted) do_resume(32'h9000);
    issue(1'b1, 32'h9000, 1'b0, 32'h0, r, w);
    if (halted) do_resume(32'h9002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R7 watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic r;
    logic [1:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 halt_req after reset", 32'(halt_req), 32'd0);
    chk("R1 halt_why after reset", 32'(halt_why), 32'd0);
    chk("R1 halted after reset", 32'(halted), 32'd0);
    issue(1'b1, 32'h0, 1'b0, 32'h0, r, w);
    chk("R1 no hit with reset slots", 32'(r), 32'd0);

    cfg(2'd0, 32'h1000, 1'b1, 1'b0);
    cfg(2'd1, 32'h1004, 1'b1, 1'b0);
    cfg(2'd2, 32'h2000, 1'b1, 1'b1);
    cfg(2'd3, 32'h2002, 1'b1, 1'b1);

    for (int k = 0; k < NVEC; k++) begin
      issue(TBL[k].av, TBL[k].aa, TBL[k].bv, TBL[k].ba, r, w);
      chk($sformatf("R3/R4/R5/R10 vec %0d req", k), 32'(r), 32'(TBL[k].req));
      chk($sformatf("R3/R4/R5/R10 vec %0d why", k), 32'(w), 32'(TBL[k].why));
      @(negedge clk);
      chk($sformatf("R7 vec %0d one-cycle pulse", k), 32'(halt_req), 32'd0);
      chk($sformatf("R7 vec %0d halted level", k), 32'(halted), 32'(TBL[k].req));
      settle();
    end

    // R6 mixed pair: before on A, after on B
    issue(1'b1, 32'h1004, 1'b1, 32'h2002, r, w);
    chk("R6 first halt req", 32'(r), 32'd1);
    chk("R6 first halt why", 32'(w), 32'd1);
    do_resume(32'h1004);
    issue(1'b1, 32'h1004, 1'b1, 32'h2002, r, w);
    chk("R6 pending halt req", 32'(r), 32'd1);
    chk("R6 pending halt why", 32'(w), 32'd3);
    settle();

    // R8 suppression for one issue only
    issue(1'b1, 32'h1000, 1'b0, 32'h0, r, w);
    chk("R8 initial before halt", 32'(w), 32'd1);
    do_resume(32'h1000);
    issue(1'b1, 32'h1000, 1'b0, 32'h0, r, w);
    chk("R8 first issue suppressed", 32'(r), 32'd0);
    issue(1'b1, 32'h1000, 1'b0, 32'h0, r, w);
    chk("R8 second issue halts", 32'(r), 32'd1);
    chk("R8 second issue why", 32'(w), 32'd1);
    settle();

    // R7 issues while halted are ignored; resume while running ignored
    issue(1'b1, 32'h1000, 1'b0, 32'h0, r, w);
    issue(1'b1, 32'h2000, 1'b0, 32'h0, r, w);
    chk("R7 issue while halted no req", 32'(r), 32'd0);
    chk("R7 still halted", 32'(halted), 32'd1);
    settle();
    do_resume(32'h1000);
    chk("R7 resume while running keeps halted 0", 32'(halted), 32'd0);
    issue(1'b1, 32'h1000, 1'b0, 32'h0, r, w);
    chk("R7 stray resume arms no suppression", 32'(r), 32'd1);
    settle();

    // R9 after-halt then before breakpoint at the next address
    issue(1'b1, 32'h2000, 1'b0, 32'h0, r, w);
    chk("R9 after halt why", 32'(w), 32'd2);
    cfg(2'd3, 32'h2002, 1'b1, 1'b0);
    do_resume(32'h2002);
    issue(1'b1, 32'h2002, 1'b0, 32'h0, r, w);
    chk("R9 consecutive before halts", 32'(r), 32'd1);
    chk("R9 consecutive before why", 32'(w), 32'd1);
    settle();

    // R2 disabling a slot
    cfg(2'd0, 32'h1000, 1'b0, 1'b0);
    issue(1'b1, 32'h1000, 1'b0, 32'h0, r, w);
    chk("R2 disabled slot no hit", 32'(r), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule